// File: doc/BRIEF.md
# CAN Receive FIFO Acceptance Filter

This block decides whether a received CAN frame may be written into a receive FIFO. It compares the frame's identifier and its extended and remote flags against a table of eight 32-bit filter words. A two-bit format setting applies to the whole table and decides how each word is split:

- **Format A:** one full-identifier element per word.
- **Format B:** two 14-bit partial-identifier elements per word.
- **Format C:** four 8-bit identifier-prefix elements per word.

The setting and the table can only be written while the freeze input is high.

When the frame-valid strobe is sampled while the block is idle, the frame is captured and the table is scanned one word per clock. The scan stops at the first matching element. It then pulses `done` with the accept decision and the index of the matching element. The element index counts sub-elements in table order. Identifiers arrive as 29 bits, and a standard identifier is left-aligned in bits 28..18.

Top module: `can_rxfifo_filter`

## Requirements
- R1: After reset, `busy`, `done`, `accept` and `hit_idx` are 0, all table words are 0 and the format is A (code 00). A standard data frame with ID 0 is then accepted with `hit_idx` 0.
- R2: A table write (`tbl_we`) or a format write (`mode_we`, codes 00=A, 01=B, 10=C, 11=off) takes effect only if `freeze` is 1 in the same cycle. Otherwise it is ignored.
- R3: Format A word layout: bit 31 is the remote select, bit 30 is the extended select and bits 28..0 are the identifier. An extended frame matches on all 29 bits. A standard frame matches on bits 28..18 only.
- R4: In formats A and B, an element with remote select 0 matches only data frames, and one with remote select 1 matches only remote frames. An element with extended select 0 matches only standard frames, and one with extended select 1 matches only extended frames.
- R5: Format B: element 0 of a word is bits 31..16 and element 1 is bits 15..0. Within each 16-bit half, bit 15 is the remote select, bit 14 is the extended select and bits 13..0 are the ID field. For an extended frame, the ID field is compared with ID bits 28..15. For a standard frame, field bits 13..3 are compared with ID bits 28..18.
- R6: Format C: element j of a word is byte bits (31-8j)..(24-8j). Each element is compared with ID bits 28..21 for any frame type and either value of the remote flag.
- R7: With format code 11, no frame is accepted.
- R8: The lowest-numbered matching element wins. `hit_idx` is word*1 + element in A, word*2 + element in B and word*4 + element in C.
- R9: `done` is a one-cycle pulse. If the match is in word k, `done` is high in the (k+1)-th clock after the clock that sampled the strobe. If no element matches, `done` is high in the 8th clock.
- R10: `busy` is 1 from the clock after the strobe until `done` rises, and it is 0 while `done` is high. Strobes that arrive while `busy` is 1 are ignored and are not queued.
- R11: `accept` and `hit_idx` are updated when `done` rises and then held. On a reject, `accept` is 0 and `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Enables table and format writes |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | 3 | Table word address |
| tbl_wdata | input | 32 | Table word data |
| mode_we | input | 1 | Format write strobe |
| mode_wdata | input | 2 | Format code: 00 A, 01 B, 10 C, 11 off |
| frm_valid | input | 1 | Received frame strobe |
| frm_id | input | 29 | Received identifier, standard IDs in bits 28..18 |
| frm_ide | input | 1 | 1 = extended frame |
| frm_rtr | input | 1 | 1 = remote frame |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result pulse |
| accept | output | 1 | Frame accepted |
| hit_idx | output | 5 | Index of matching element |

## Verification
The bench goes after the following corner cases, each paired with the symptom a faulty design would show:

- **Standard frames in formats A and B.** The low identifier bits must not take part in the compare. A design that compared them would reject matching standard frames.
- **Remote and extended select bits.** A design that ignored these bits would accept data frames on remote-only entries.
- **Format B halves and format C bytes.** A design that numbered elements from the wrong end would report the wrong `hit_idx` when two elements match.
- **Scan latency and busy.** The latency is checked on every frame against the matching word. A design that kept scanning after a hit, or restarted on a mid-scan strobe, would show a wrong `done` cycle or a late `busy`.
- **Writes without freeze.** These writes are followed by frames whose outcome depends on whether the write landed.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    localparam int NUM_WORDS = 8;
    localparam int WORD_W    = 32;
    localparam int ID_W      = 29;
    localparam int ADDR_W    = $clog2(NUM_WORDS);
    localparam int IDX_W     = ADDR_W + 2;

    typedef enum logic [1:0] {
        FMT_A   = 2'b00,
        FMT_B   = 2'b01,
        FMT_C   = 2'b10,
        FMT_OFF = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            ide;
        logic            rtr;
    } frame_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] sub;
    } wmatch_t;

    // full-ID element: [31] remote sel, [30] ext sel, [28:0] id
    function automatic logic elem_full(input logic [WORD_W-1:0] w, input frame_t f);
        logic same_kind;
        same_kind = (w[31] == f.rtr) && (w[30] == f.ide);
        if (f.ide) return same_kind && (w[28:0] == f.id);
        return same_kind && (w[28:18] == f.id[28:18]);
    endfunction

    // half element: [15] remote sel, [14] ext sel, [13:0] id field
    function automatic logic elem_half(input logic [15:0] h, input frame_t f);
        logic same_kind;
        same_kind = (h[15] == f.rtr) && (h[14] == f.ide);
        if (f.ide) return same_kind && (h[13:0] == f.id[28:15]);
        return same_kind && (h[13:3] == f.id[28:18]);
    endfunction

    function automatic logic elem_prefix(input logic [7:0] b, input frame_t f);
        return b == f.id[28:21];
    endfunction

endpackage

// File: rtl/can_flt_table.sv
module can_flt_table
    import can_flt_pkg::*;
#(
    parameter int N_WORDS = NUM_WORDS,
    parameter int A_W     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic              tbl_we,
    input  logic [A_W-1:0]    tbl_addr,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    input  logic [A_W-1:0]    rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output fmt_e              mode
);

    logic [N_WORDS-1:0][WORD_W-1:0] words_q;
    fmt_e                           mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
            mode_q  <= FMT_A;
        end else if (freeze) begin
            if (tbl_we)  words_q[tbl_addr] <= tbl_wdata;
            if (mode_we) mode_q <= fmt_e'(mode_wdata);
        end
    end

    assign rd_word = words_q[rd_addr];
    assign mode    = mode_q;

    // R2
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !freeze |=> $stable(mode_q));
    // R2
    table_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !freeze |=> $stable(words_q));

endmodule

// File: rtl/can_flt_word_match.sv
module can_flt_word_match
    import can_flt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  frame_t            frame,
    input  fmt_e              mode,
    output wmatch_t           result
);

    localparam int N_HALF = 2;
    localparam int N_BYTE = 4;

    logic [N_HALF-1:0] half_hit;
    logic [N_BYTE-1:0] byte_hit;

    for (genvar j = 0; j < N_HALF; j++) begin : g_half
        assign half_hit[j] = elem_half(word[WORD_W-1-16*j -: 16], frame);
    end

    for (genvar j = 0; j < N_BYTE; j++) begin : g_byte
        assign byte_hit[j] = elem_prefix(word[WORD_W-1-8*j -: 8], frame);
    end

    always_comb begin
        result = '0;
        unique case (mode)
            FMT_A: result.hit = elem_full(word, frame);
            FMT_B: begin
                for (int j = N_HALF - 1; j >= 0; j--) begin
                    if (half_hit[j]) begin
                        result.hit = 1'b1;
                        result.sub = 2'(j);
                    end
                end
            end
            FMT_C: begin
                for (int j = N_BYTE - 1; j >= 0; j--) begin
                    if (byte_hit[j]) begin
                        result.hit = 1'b1;
                        result.sub = 2'(j);
                    end
                end
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/can_flt_scan.sv
module can_flt_scan
    import can_flt_pkg::*;
#(
    parameter int N_WORDS = NUM_WORDS,
    parameter int A_W     = ADDR_W,
    parameter int I_W     = IDX_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           frm_valid,
    input  frame_t         frame_in,
    input  fmt_e           mode,
    input  wmatch_t        wres,
    output logic [A_W-1:0] ptr,
    output frame_t         frame_cur,
    output logic           busy,
    output logic           done,
    output logic           accept,
    output logic [I_W-1:0] hit_idx
);

    localparam logic [A_W-1:0] LAST = A_W'(N_WORDS - 1);

    logic           busy_q, done_q, accept_q;
    logic [A_W-1:0] ptr_q;
    logic [I_W-1:0] idx_q, idx_calc;
    frame_t         frame_q;

    always_comb begin
        unique case (mode)
            FMT_B:   idx_calc = I_W'({ptr_q, wres.sub[0]});
            FMT_C:   idx_calc = I_W'({ptr_q, wres.sub});
            default: idx_calc = I_W'(ptr_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            accept_q <= 1'b0;
            ptr_q    <= '0;
            idx_q    <= '0;
            frame_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (frm_valid) begin
                    busy_q  <= 1'b1;
                    ptr_q   <= '0;
                    frame_q <= frame_in;
                end
            end else if (wres.hit || ptr_q == LAST) begin
                busy_q   <= 1'b0;
                done_q   <= 1'b1;
                accept_q <= wres.hit;
                idx_q    <= wres.hit ? idx_calc : '0;
            end else begin
                ptr_q <= ptr_q + A_W'(1);
            end
        end
    end

    assign ptr       = ptr_q;
    assign frame_cur = frame_q;
    assign busy      = busy_q;
    assign done      = done_q;
    assign accept    = accept_q;
    assign hit_idx   = idx_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(busy_q) && !busy_q);
    // R10
    scan_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && !wres.hit && ptr_q != LAST |=> busy_q && ptr_q == $past(ptr_q) + A_W'(1));
    // R11
    reject_idx_chk: assert property (@(posedge clk) disable iff (rst)
        done_q && !accept_q |-> idx_q == '0);

endmodule

// File: rtl/can_rxfifo_filter.sv
module can_rxfifo_filter
    import can_flt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    input  logic              frm_valid,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    output logic              busy,
    output logic              done,
    output logic              accept,
    output logic [IDX_W-1:0]  hit_idx
);

    logic [ADDR_W-1:0] ptr;
    logic [WORD_W-1:0] word;
    fmt_e              mode;
    frame_t            frame_in, frame_cur;
    wmatch_t           wres;

    assign frame_in = '{id: frm_id, ide: frm_ide, rtr: frm_rtr};

    can_flt_table u_table (
        .clk        (clk),
        .rst        (rst),
        .freeze     (freeze),
        .tbl_we     (tbl_we),
        .tbl_addr   (tbl_addr),
        .tbl_wdata  (tbl_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .rd_addr    (ptr),
        .rd_word    (word),
        .mode       (mode)
    );

    can_flt_word_match u_match (
        .word   (word),
        .frame  (frame_cur),
        .mode   (mode),
        .result (wres)
    );

    can_flt_scan u_scan (
        .clk       (clk),
        .rst       (rst),
        .frm_valid (frm_valid),
        .frame_in  (frame_in),
        .mode      (mode),
        .wres      (wres),
        .ptr       (ptr),
        .frame_cur (frame_cur),
        .busy      (busy),
        .done      (done),
        .accept    (accept),
        .hit_idx   (hit_idx)
    );

endmodule

// File: tb/can_rxfifo_filter_tb.sv
module can_rxfifo_filter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        freeze = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic        frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic        frm_ide = 1'b0;
    logic        frm_rtr = 1'b0;
    logic        busy, done, accept;
    logic [4:0]  hit_idx;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] m_tbl [8];
    logic [1:0]  m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_rxfifo_filter dut_i (
        .clk(clk), .rst(rst), .freeze(freeze),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .frm_valid(frm_valid), .frm_id(frm_id), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
        .busy(busy), .done(done), .accept(accept), .hit_idx(hit_idx)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int per_word(input logic [1:0] md);
        return (md == 2'd0) ? 1 : (md == 2'd1) ? 2 : 4;
    endfunction

    // returns {accept, idx}
    function automatic logic [5:0] ref_eval(input logic [1:0] md, input logic [28:0] id,
                                            input logic ide, input logic rtr);
        logic [31:0] x, sh;
        logic [15:0] h;
        logic [7:0]  b;
        logic        m;
        int          n;
        if (md == 2'd3) return 6'd0;
        n = per_word(md);
        for (int w = 0; w < 8; w++) begin
            x = m_tbl[w];
            for (int e = 0; e < n; e++) begin
                m = 1'b0;
                if (md == 2'd0) begin
                    m = (x[31] == rtr) && (x[30] == ide) &&
                        (ide ? (x[28:0] == id) : (x[28:18] == id[28:18]));
                end else if (md == 2'd1) begin
                    sh = x >> (16 * (1 - e));
                    h  = sh[15:0];
                    m  = (h[15] == rtr) && (h[14] == ide) &&
                         (ide ? (h[13:0] == id[28:15]) : (h[13:3] == id[28:18]));
                end else begin
                    sh = x >> (8 * (3 - e));
                    b  = sh[7:0];
                    m  = (b == id[28:21]);
                end
                if (m) return {1'b1, 5'(w * n + e)};
            end
        end
        return 6'd0;
    endfunction

    task automatic wr_word(input int a, input logic [31:0] d, input logic frz);
        @(negedge clk);
        freeze = frz; tbl_we = 1'b1; tbl_addr = 3'(a); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0; freeze = 1'b0;
        if (frz) m_tbl[a] = d;
    endtask

    task automatic wr_mode(input logic [1:0] md, input logic frz);
        @(negedge clk);
        freeze = frz; mode_we = 1'b1; mode_wdata = md;
        @(negedge clk);
        mode_we = 1'b0; freeze = 1'b0;
        if (frz) m_mode = md;
    endtask

    // send a frame; if spoil, a second strobe with another ID is sent mid-scan
    task automatic send(input string req, input logic [28:0] id, input logic ide,
                        input logic rtr, input logic spoil);
        logic [5:0] exp;
        int lat, n;
        exp = ref_eval(m_mode, id, ide, rtr);
        n   = per_word(m_mode);
        @(negedge clk);
        frm_valid = 1'b1; frm_id = id; frm_ide = ide; frm_rtr = rtr;
        @(negedge clk);
        frm_valid = 1'b0;
        check("R10", "busy after strobe", int'(busy), 1);
        lat = 0;
        while (lat < 20) begin
            if (spoil && lat == 1) begin
                frm_valid = 1'b1; frm_id = ~id; frm_ide = ~ide; frm_rtr = ~rtr;
            end else begin
                frm_valid = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (done) break;
            if (!busy) begin
                errors++; checks++;
                $display("FAIL R10 busy dropped early: actual=0 expected=1");
            end
        end
        frm_valid = 1'b0;
        check("R9", "done latency", lat, exp[5] ? (int'(exp[4:0]) / n) + 1 : 8);
        check("R10", "busy low at done", int'(busy), 0);
        check(req, "accept", int'(accept), int'(exp[5]));
        check("R8", "hit_idx", int'(hit_idx), int'(exp[4:0]));
        @(negedge clk);
        check("R9", "done one pulse", int'(done), 0);
        check("R10", "no queued scan", int'(busy), 0);
        check("R11", "accept held", int'(accept), int'(exp[5]));
        check("R11", "idx held", int'(hit_idx), int'(exp[4:0]));
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<200000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [28:0] idx_id, rid;
        logic [31:0] w;
        logic [15:0] h;
        logic        ide, rtr;
        int          wi, ei;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_tbl[i] = '0;
        m_mode = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "accept", int'(accept), 0);
        check("R1", "hit_idx", int'(hit_idx), 0);
        send("R1", 29'd0, 1'b0, 1'b0, 1'b0);

        // R2 writes without freeze ignored
        wr_word(0, 32'h0000_0000, 1'b1);
        for (int i = 1; i < 8; i++) wr_word(i, 32'hFFFF_FFFF, 1'b1);
        wr_word(0, 32'h0004_0000, 1'b0);
        send("R2", 29'h0004_0000, 1'b0, 1'b0, 1'b0);   // still rejected
        wr_word(0, 32'h0004_0000, 1'b1);
        send("R2", 29'h0004_0000, 1'b0, 1'b0, 1'b0);   // now idx0
        wr_mode(2'd1, 1'b0);
        send("R2", 29'h0004_3FFF, 1'b0, 1'b0, 1'b0);   // still format A
        wr_mode(2'd1, 1'b1);
        send("R2", 29'h0004_0000, 1'b0, 1'b0, 1'b0);   // format B rejects
        wr_mode(2'd0, 1'b1);

        // R3 / R4 format A
        idx_id = 29'h0ABC_DEF1;
        wr_word(2, {3'b010, idx_id}, 1'b1);
        wr_word(3, {3'b110, idx_id}, 1'b1);
        send("R3", idx_id, 1'b1, 1'b0, 1'b0);
        send("R3", idx_id ^ 29'h1, 1'b1, 1'b0, 1'b0);
        send("R4", idx_id, 1'b1, 1'b1, 1'b0);
        send("R4", idx_id, 1'b0, 1'b0, 1'b0);
        wr_word(5, 32'h0004_0000, 1'b1);
        send("R3", 29'h0007_FFFF, 1'b0, 1'b0, 1'b0);   // low bits ignored
        send("R4", 29'h0004_0000, 1'b0, 1'b1, 1'b0);
        wr_word(0, 32'hFFFF_FFFF, 1'b1);
        send("R8", 29'h0004_1234, 1'b0, 1'b0, 1'b0);   // word5 only
        wr_word(1, 32'h0004_0000, 1'b1);
        send("R8", 29'h0004_1234, 1'b0, 1'b0, 1'b0);   // word1 wins

        // R5 format B
        wr_mode(2'd1, 1'b1);
        for (int i = 0; i < 8; i++) wr_word(i, 32'hFFFF_FFFF, 1'b1);
        h = {2'b01, idx_id[28:15]};
        wr_word(1, {16'hFFFF, h}, 1'b1);
        send("R5", idx_id, 1'b1, 1'b0, 1'b0);
        send("R5", idx_id ^ 29'h0000_8000, 1'b1, 1'b0, 1'b0);
        send("R4", idx_id, 1'b1, 1'b1, 1'b0);
        wr_word(3, {2'b10, idx_id[28:18], 3'b101, 16'hFFFF}, 1'b1);
        send("R5", {idx_id[28:18], 18'h2AAAA}, 1'b0, 1'b1, 1'b0);

        // R6 format C
        wr_mode(2'd2, 1'b1);
        for (int i = 0; i < 8; i++) wr_word(i, 32'hFFFF_FFFF, 1'b1);
        wr_word(2, {16'hFFFF, idx_id[28:21], 8'hFF}, 1'b1);
        wr_word(5, {idx_id[28:21], 24'hFFFFFF}, 1'b1);
        send("R6", idx_id, 1'b0, 1'b1, 1'b0);
        send("R6", idx_id, 1'b1, 1'b0, 1'b0);
        send("R6", idx_id ^ 29'h0020_0000, 1'b1, 1'b0, 1'b0);

        // R7 off
        wr_mode(2'd3, 1'b1);
        send("R7", 29'h1FFF_FFFF, 1'b1, 1'b1, 1'b0);
        send("R7", idx_id, 1'b0, 1'b0, 1'b0);

        // R10 mid-scan strobe ignored
        wr_mode(2'd0, 1'b1);
        send("R10", 29'h1555_5555, 1'b1, 1'b0, 1'b1);
        wr_word(4, {3'b010, idx_id}, 1'b1);
        send("R10", idx_id, 1'b1, 1'b0, 1'b1);

        // random
        for (int md = 0; md < 4; md++) begin
            wr_mode(2'(md), 1'b1);
            for (int i = 0; i < 8; i++) begin
                if (i > 0 && $urandom_range(0, 3) == 0) wr_word(i, m_tbl[i-1], 1'b1);
                else wr_word(i, $urandom, 1'b1);
            end
            for (int k = 0; k < 60; k++) begin
                wi  = $urandom_range(0, 7);
                w   = m_tbl[wi];
                rid = 29'($urandom);
                ide = 1'($urandom);
                rtr = 1'($urandom);
                if (md == 0) begin
                    rtr = w[31]; ide = w[30];
                    rid = ide ? w[28:0] : {w[28:18], rid[17:0]};
                end else if (md == 1) begin
                    ei = $urandom_range(0, 1);
                    h  = ei == 0 ? w[31:16] : w[15:0];
                    rtr = h[15]; ide = h[14];
                    rid = ide ? {h[13:0], rid[14:0]} : {h[13:3], rid[17:0]};
                end else if (md == 2) begin
                    ei  = $urandom_range(0, 3);
                    rid = {8'(w >> (8 * (3 - ei))), rid[20:0]};
                end
                if ($urandom_range(0, 3) == 0) rid = rid ^ (29'd1 << $urandom_range(15, 28));
                send(md == 0 ? "R3" : md == 1 ? "R5" : md == 2 ? "R6" : "R7",
                     rid, ide, rtr, 1'($urandom_range(0, 7) == 0));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule